// File: doc/BRIEF.md
# Peripheral Clock Gate Bank

This block holds the on/off state of the clock enables for a set of peripherals, up to 64 by default, each known by a numeric ID. Software drives it over a plain synchronous register bus made of an address, a write strobe, write data and read data. Each group of 32 IDs has its own trio of registers. A write-one-to-set register turns clocks on. A write-one-to-clear register turns them off. A read-only register reports the present state. Only the bits written as 1 act, so separate drivers can change their own peripherals without a read-modify-write.

The block drives one level enable per ID, meant to feed a clock gating cell elsewhere. The two lowest IDs are wired permanently on. Their bits read back as 1, and no write can turn them off. Read data is registered and appears one clock after the address is presented.

Top module: `periph_clk_gate_bank`

## Requirements
- R1: A write to the set register of a bank (offset 0x0 within the bank) turns on the enable of every ID whose bit is 1 in the data, from the cycle after the write. Bits written as 0 leave their IDs unchanged.
- R2: A write to the clear register of a bank (offset 0x4 within the bank) turns off the enable of every gateable ID whose bit is 1 in the data, from the cycle after the write. Bits written as 0 leave their IDs unchanged.
- R3: Presenting the status address of a bank (offset 0x8 within the bank) returns, on rdData one cycle later, the enable state of that bank's IDs as they stood before that clock edge.
- R4: ID n is controlled and reported at bit (n mod 32) of bank n/32. Bank b's registers sit at byte address 0x10*b plus the offset, so bank 0 is at 0x00, 0x04, 0x08 and bank 1 at 0x10, 0x14, 0x18. A write to one bank never changes another bank's enables.
- R5: IDs 0 and 1 are always enabled and read back as 1. Set and clear writes to their bits have no effect.
- R6: After reset every gateable enable is off, so the outputs read 0x3 and the bank 0 status reads 0x00000003.
- R7: Reads of a set or clear register, of an offset not listed in R1 to R3, or of a bank number at or above the bank count return zero. Writes to those unlisted addresses change no enable.
- R8: In a cycle with no write, no enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data, one bit per ID of the addressed bank |
| rdData | output | 32 | Registered read data for the address of the previous cycle |
| clkEn | output | NUM_IDS (64) | Clock enable, one per peripheral ID |

## Verification
The assertions assume that busWe, busAddr and busWdata are known values at every rising edge once reset is released. They also assume that a write and a status read of the same bank may share a cycle, with the read seeing the state from before the write. The stimulus changes the bus only on falling edges. It holds busWe low and the address at zero during reset, and it drives no unknown values. The locked IDs, set and clear writes to both banks, and accesses to unmapped offsets and banks are each reached by explicit bus operations, not by free-running traffic.

// File: rtl/pclk_gate_pkg.sv
package pclk_gate_pkg;

  localparam int BANK_BITS  = 32;
  localparam int BANK_SEL_W = 4;
  localparam int BANK_STRIDE_LOG2 = 4;

  localparam logic [3:0] OFS_SET  = 4'h0;
  localparam logic [3:0] OFS_CLR  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;

  typedef struct packed {
    logic                  wrSet;
    logic                  wrClr;
    logic                  rdStat;
    logic [BANK_SEL_W-1:0] bank;
  } gateStrb_t;

endpackage

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pclk_gate_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output gateStrb_t         strb
);

  localparam int FIELD_W = ADDR_W - BANK_STRIDE_LOG2;
  localparam logic [FIELD_W-1:0] BANK_LIMIT = FIELD_W'(NUM_BANKS);

  logic [FIELD_W-1:0] bankField;
  logic [3:0]         regOfs;
  logic               bankOk;

  assign bankField = busAddr[ADDR_W-1:BANK_STRIDE_LOG2];
  assign regOfs    = busAddr[BANK_STRIDE_LOG2-1:0];
  assign bankOk    = bankField < BANK_LIMIT;

  always_comb begin
    strb        = '0;
    strb.bank   = BANK_SEL_W'(bankField);
    strb.wrSet  = busWe && bankOk && (regOfs == OFS_SET);
    strb.wrClr  = busWe && bankOk && (regOfs == OFS_CLR);
    strb.rdStat = bankOk && (regOfs == OFS_STAT);
  end

endmodule

// File: rtl/pclk_gate_dp.sv
module pclk_gate_dp
  import pclk_gate_pkg::*;
#(
  parameter int NUM_IDS    = 64,
  parameter int NUM_LOCKED = 2,
  parameter int NUM_BANKS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrb_t            strb,
  input  logic [BANK_BITS-1:0] busWdata,
  output logic [NUM_IDS-1:0]   enState,
  output logic [BANK_BITS-1:0] rdData
);

  localparam int PAD_W = NUM_BANKS * BANK_BITS;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    localparam int BANK_NUM = g / BANK_BITS;
    localparam int BIT_POS  = g % BANK_BITS;
    if (g < NUM_LOCKED) begin : g_locked
      assign enState[g] = 1'b1;
    end else begin : g_gated
      logic hitSet;
      logic hitClr;
      assign hitSet = strb.wrSet && (int'(strb.bank) == BANK_NUM) && busWdata[BIT_POS];
      assign hitClr = strb.wrClr && (int'(strb.bank) == BANK_NUM) && busWdata[BIT_POS];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       enState[g] <= 1'b0;
        else if (hitClr) enState[g] <= 1'b0;
        else if (hitSet) enState[g] <= 1'b1;
      end
    end
  end

  logic [PAD_W-1:0]     padState;
  logic [BANK_BITS-1:0] rdNext;

  assign padState = PAD_W'(enState);

  always_comb begin
    rdNext = '0;
    if (strb.rdStat) rdNext = padState[int'(strb.bank)*BANK_BITS +: BANK_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/periph_clk_gate_bank.sv
module periph_clk_gate_bank
  import pclk_gate_pkg::*;
#(
  parameter int NUM_IDS    = 64,
  parameter int NUM_LOCKED = 2,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       rdData,
  output logic [NUM_IDS-1:0] clkEn
);

  localparam int NUM_BANKS = (NUM_IDS + BANK_BITS - 1) / BANK_BITS;

  gateStrb_t strb;

  pclk_gate_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  pclk_gate_dp #(
    .NUM_IDS   (NUM_IDS),
    .NUM_LOCKED(NUM_LOCKED),
    .NUM_BANKS (NUM_BANKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .enState (clkEn),
    .rdData  (rdData)
  );

endmodule

// File: rtl/pclk_gate_chk.sv
module pclk_gate_chk #(
  parameter int NUM_IDS    = 64,
  parameter int NUM_LOCKED = 2,
  parameter int ADDR_W     = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [31:0]        busWdata,
  input logic [31:0]        rdData,
  input logic [NUM_IDS-1:0] clkEn
);

  localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SET1  = ADDR_W'(8'h10);
  localparam logic [31:0] LOCK_MASK = (32'h1 << NUM_LOCKED) - 32'h1;

  // R1: set bits are on after a bank 0 set write
  p_set_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_SET0) |=> ((clkEn[31:0] & $past(busWdata)) == $past(busWdata)));

  // R2 and R5: cleared gateable bits are off, locked bits stay on
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_CLR0) |=>
      (((clkEn[31:0] & $past(busWdata) & ~LOCK_MASK) == 32'h0) &&
       ((clkEn[31:0] & LOCK_MASK) == LOCK_MASK)));

  // R3: status read returns the state before the edge
  p_stat_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_STAT0) |=> (rdData == $past(clkEn[31:0])));

  // R4: a bank 0 access leaves bank 1 untouched
  if (NUM_IDS > 32) begin : g_two_banks
    p_bank_iso_r4: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr[ADDR_W-1:4] == '0) |=> $stable(clkEn[NUM_IDS-1:32]));
    p_bank1_iso_r4: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == A_SET1) |=> $stable(clkEn[31:0]));
  end

  // R7: write-only registers read as zero
  p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_SET0 || busAddr == A_CLR0) |=> (rdData == 32'h0));

  // R8: no write, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(clkEn));

endmodule

bind periph_clk_gate_bank pclk_gate_chk #(
  .NUM_IDS   (NUM_IDS),
  .NUM_LOCKED(NUM_LOCKED),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .rdData  (rdData),
  .clkEn   (clkEn)
);

// File: tb/tb_periph_clk_gate_bank.sv
`timescale 1ns/1ps
module tb_periph_clk_gate_bank;

  localparam int NUM_IDS = 64;
  localparam int ADDR_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       rdData;
  logic [NUM_IDS-1:0] clkEn;

  periph_clk_gate_bank #(.NUM_IDS(NUM_IDS), .NUM_LOCKED(2), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .rdData(rdData), .clkEn(clkEn)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t expQ[$];

  int nCmp = 0;
  int nBad = 0;
  logic [63:0] mdl = 64'h3;
  logic readIssued = 1'b0;
  logic chkNow = 1'b0;
  bit done = 0;

  // reference model of a write, built from the register map
  function automatic void mdlWrite(logic [7:0] a, logic [31:0] d);
    int bank = int'(a[7:4]);
    if (bank < 2) begin
      if (a[3:0] == 4'h0) mdl[bank*32 +: 32] = mdl[bank*32 +: 32] | d;
      if (a[3:0] == 4'h4) mdl[bank*32 +: 32] = mdl[bank*32 +: 32] & ~d;
    end
    mdl[1:0] = 2'b11;
  endfunction

  function automatic logic [31:0] mdlRead(logic [7:0] a);
    int bank = int'(a[7:4]);
    if (bank < 2 && a[3:0] == 4'h8) return mdl[bank*32 +: 32];
    return 32'h0;
  endfunction

  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    mdlWrite(a, d);
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(logic [7:0] a, string tag);
    item_t it;
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    it.exp = mdlRead(a); it.tag = tag;
    expQ.push_back(it);
    readIssued = 1'b1;
    @(negedge clk);
    readIssued = 1'b0;
  endtask

  task automatic checkEn(string tag);
    nCmp++;
    if (clkEn !== mdl) begin
      nBad++;
      $display("FAIL %s clkEn actual=%h expected=%h", tag, clkEn, mdl);
    end
  endtask

  always @(posedge clk) chkNow <= readIssued;

  always @(negedge clk) begin
    if (chkNow) begin
      item_t it;
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL monitor rdData actual=%h expected=<none>", rdData);
      end else begin
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          nBad++;
          $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEn("R6 reset enables");
    doRead(8'h08, "R6 bank0 status after reset");
    doRead(8'h18, "R6 bank1 status after reset");

    doWrite(8'h00, 32'h0000_00F0);
    checkEn("R1 set bank0");
    doRead(8'h08, "R1 R3 status after set");

    doWrite(8'h00, 32'h8000_0001);
    checkEn("R1 R5 set top bit and locked bit");
    doWrite(8'h00, 32'h0000_0000);
    checkEn("R1 zero write no effect");

    doWrite(8'h04, 32'h0000_0013);
    checkEn("R2 R5 clear with locked bits");
    doRead(8'h08, "R2 status after clear");

    doWrite(8'h10, 32'h0000_0005);
    checkEn("R4 set bank1");
    doRead(8'h18, "R4 bank1 status");
    doRead(8'h08, "R4 bank0 untouched");
    doWrite(8'h14, 32'h0000_0001);
    checkEn("R4 clear bank1 id32");
    doRead(8'h18, "R4 bank1 status after clear");

    doRead(8'h00, "R7 set register reads zero");
    doRead(8'h14, "R7 clear register reads zero");
    doRead(8'h0C, "R7 unmapped offset reads zero");
    doRead(8'h28, "R7 missing bank reads zero");
    doWrite(8'h0C, 32'hFFFF_FFFF);
    checkEn("R7 unmapped offset write ignored");
    doWrite(8'h20, 32'hFFFF_FFFF);
    checkEn("R7 missing bank write ignored");

    repeat (4) @(negedge clk);
    checkEn("R8 idle hold");

    doWrite(8'h00, 32'hFFFF_FFFF);
    doWrite(8'h10, 32'hFFFF_FFFF);
    checkEn("R1 R4 all set");
    doWrite(8'h04, 32'hFFFF_FFFF);
    checkEn("R2 R5 all clear bank0");
    doRead(8'h08, "R5 locked ids read one");
    doRead(8'h18, "R4 bank1 survives bank0 clear");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nCmp++; nBad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=%0d expected=<done>", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule